// File: doc/BRIEF.md
# Address aging timestamp controller

This block keeps a small table of learned source addresses and ages them with two 8-bit stamp counters: a current stamp and a purge stamp. The frame path presents one source address per request. An address that is not yet known is written into a free row together with its port ID and the current stamp. An address that is already known has its port ID and stamp refreshed. Rows created by the host as permanent are never refreshed or purged.

An increment pulse advances both counters together and then schedules a purge. The purge deletes, in one cycle, every non-permanent row whose stored stamp equals the new purge stamp. The gap between the two counters therefore sets how many increment periods an idle address survives. The host can insert a permanent row, delete a row, read a row, or step either counter on its own. The frame path always wins: while a learn request is present, neither the purge nor a host operation executes.

The control state machine has four states. `S_IDLE` waits for work. `S_PURGE` runs the purge. `S_MGMT` runs the latched host operation. `S_ACK` raises the host acknowledge for one cycle. The transitions are as follows:
- IDLE→PURGE when a purge is pending.
- IDLE→MGMT when the host requests and no purge is pending.
- PURGE→IDLE in the first cycle without a learn request.
- MGMT→ACK in the first cycle without a learn request.
- ACK→IDLE always.

Top module: `age_stamp_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low for at least two clocks), both stamps read 0, `table_full` and `host_ack` are 0, and a host read of any address misses.
- R2: A rising edge on `incr_in` while `cfg_incr_en` is 2'b11 adds one to both `cur_stamp` and `purge_stamp` at the next clock. Holding `incr_in` high for several cycles counts only once.
- R3: While `cfg_incr_en` is not 2'b11, `incr_in` has no effect: both stamps keep their values and no purge occurs.
- R4: After an enabled increment, every non-permanent row whose stamp equals the new `purge_stamp` is deleted. All other rows, and all permanent rows, remain.
- R5: A learn request (`learn_valid` high for one cycle) with an unknown address stores that address with `learn_port`, the current stamp, and permanent = 0.
- R6: A learn request with an address held in a non-permanent row replaces that row's port and stamp with `learn_port` and `cur_stamp`. No second row is created.
- R7: A learn request with an address held in a permanent row leaves that row unchanged.
- R8: A learn request with an unknown address while all rows are in use is dropped and sets `table_full`. The flag stays set until a purge or a host delete removes a row.
- R9: While `learn_valid` is high, no purge and no host operation executes, and `host_ack` does not rise in the following cycle.
- R10: The host operation codes on `host_op` are: 1 = insert permanent (port `host_port`, current stamp), 2 = delete, 3 = read, 4 = step current stamp, 5 = step purge stamp. `host_req` is held until `host_ack`, which is a one-cycle pulse. Read results are valid from that pulse onward.
- R11: Host code 4 adds one to `cur_stamp` only, and code 5 adds one to `purge_stamp` only. Neither code triggers a purge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| learn_valid | input | 1 | Frame-path learn request, one cycle per address |
| learn_addr | input | 48 | Source address to learn or refresh |
| learn_port | input | 6 | Port ID that goes with the address |
| incr_in | input | 1 | Increment pulse, acted on at its rising edge |
| cfg_incr_en | input | 2 | Both bits set enable `incr_in` |
| host_req | input | 1 | Host operation request, held until acknowledge |
| host_op | input | 3 | Host operation code |
| host_addr | input | 48 | Address for insert, delete or read |
| host_port | input | 6 | Port ID for insert |
| host_ack | output | 1 | One-cycle completion pulse |
| host_hit | output | 1 | Last read found the address |
| host_perm | output | 1 | Permanent bit of the row that was read |
| host_rd_port | output | 6 | Port ID of the row that was read |
| host_rd_stamp | output | 8 | Stamp of the row that was read |
| cur_stamp | output | 8 | Current stamp counter |
| purge_stamp | output | 8 | Purge stamp counter |
| table_full | output | 1 | Sticky flag: a learn or insert found no free row |

## Verification
The checker watches, on every cycle, the counter arithmetic: a single step on an enabled edge, no change while disabled, and host steps that touch only their own counter. It also checks that the acknowledge is a single pulse, that it never follows a cycle with a learn request, and that the full flag only rises on a learn or insert. What the table holds can only be seen through the bench's scenarios: rows that survive or vanish in a purge, refresh versus new entry, permanent rows that resist learning, and the full flag clearing after a delete.

// File: rtl/age_pkg.sv
package age_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PURGE = 2'd1,
        S_MGMT  = 2'd2,
        S_ACK   = 2'd3
    } age_state_e;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_INS_PERM = 3'd1,
        OP_DELETE   = 3'd2,
        OP_READ     = 3'd3,
        OP_BUMP_CUR = 3'd4,
        OP_BUMP_PUR = 3'd5
    } age_op_e;
endpackage

// File: rtl/age_incr_edge.sv
module age_incr_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       incr_in,
    input  logic [1:0] enable,
    output logic       edge_o
);
    logic incr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) incr_q <= 1'b0;
        else        incr_q <= incr_in;
    end

    assign edge_o = incr_in && !incr_q && (&enable);
endmodule

// File: rtl/age_stamp_pair.sv
module age_stamp_pair #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_both,
    input  logic          step_cur,
    input  logic          step_pur,
    output logic [SW-1:0] cur,
    output logic [SW-1:0] pur
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
            pur <= '0;
        end else begin
            cur <= cur + SW'(step_both) + SW'(step_cur);
            pur <= pur + SW'(step_both) + SW'(step_pur);
        end
    end
endmodule

// File: rtl/age_match.sv
module age_match #(
    parameter int N  = 16,
    parameter int AW = 48,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx,
    output logic                 free,
    output logic [IW-1:0]        free_idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free     = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!vld[i]) begin
                free     = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/age_stamp_ctrl.sv
module age_stamp_ctrl
    import age_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 48,
    parameter int PW = 6,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          learn_valid,
    input  logic [AW-1:0] learn_addr,
    input  logic [PW-1:0] learn_port,
    input  logic          incr_in,
    input  logic [1:0]    cfg_incr_en,
    input  logic          host_req,
    input  logic [2:0]    host_op,
    input  logic [AW-1:0] host_addr,
    input  logic [PW-1:0] host_port,
    output logic          host_ack,
    output logic          host_hit,
    output logic          host_perm,
    output logic [PW-1:0] host_rd_port,
    output logic [SW-1:0] host_rd_stamp,
    output logic [SW-1:0] cur_stamp,
    output logic [SW-1:0] purge_stamp,
    output logic          table_full
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    age_state_e state, nxt;
    age_op_e    op_q;
    logic [AW-1:0] addr_q;
    logic [PW-1:0] port_q;
    logic          purge_pend;

    logic [N-1:0]         tbl_v, tbl_p;
    logic [N-1:0][AW-1:0] tbl_a;
    logic [N-1:0][PW-1:0] tbl_port;
    logic [N-1:0][SW-1:0] tbl_st;

    logic          incr_edge;
    logic          l_hit, l_free, h_hit, h_free;
    logic [IW-1:0] l_idx, l_fidx, h_idx, h_fidx;
    logic [N-1:0]  purge_hit;
    logic          do_purge, do_exec, bump_cur, bump_pur;

    age_incr_edge u_edge (
        .clk(clk), .rst_n(rst_n), .incr_in(incr_in),
        .enable(cfg_incr_en), .edge_o(incr_edge)
    );

    age_stamp_pair #(.SW(SW)) u_stamps (
        .clk(clk), .rst_n(rst_n), .step_both(incr_edge),
        .step_cur(bump_cur), .step_pur(bump_pur),
        .cur(cur_stamp), .pur(purge_stamp)
    );

    age_match #(.N(N), .AW(AW)) u_learn_lu (
        .vld(tbl_v), .tags(tbl_a), .key(learn_addr),
        .hit(l_hit), .hit_idx(l_idx), .free(l_free), .free_idx(l_fidx)
    );

    age_match #(.N(N), .AW(AW)) u_host_lu (
        .vld(tbl_v), .tags(tbl_a), .key(addr_q),
        .hit(h_hit), .hit_idx(h_idx), .free(h_free), .free_idx(h_fidx)
    );

    for (genvar g = 0; g < N; g++) begin : g_purge
        assign purge_hit[g] = tbl_v[g] && !tbl_p[g] && (tbl_st[g] == purge_stamp);
    end

    assign do_purge = (state == S_PURGE) && !learn_valid;
    assign do_exec  = (state == S_MGMT) && !learn_valid;
    assign bump_cur = do_exec && (op_q == OP_BUMP_CUR);
    assign bump_pur = do_exec && (op_q == OP_BUMP_PUR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (purge_pend)    nxt = S_PURGE;
                else if (host_req) nxt = S_MGMT;
            end
            S_PURGE: if (!learn_valid) nxt = S_IDLE;
            S_MGMT:  if (!learn_valid) nxt = S_ACK;
            S_ACK:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ack = (state == S_ACK);
    end

    // host request capture and purge bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NOP;
            addr_q     <= '0;
            port_q     <= '0;
            purge_pend <= 1'b0;
        end else begin
            if (state == S_IDLE && !purge_pend && host_req) begin
                op_q   <= age_op_e'(host_op);
                addr_q <= host_addr;
                port_q <= host_port;
            end
            if (incr_edge)     purge_pend <= 1'b1;
            else if (do_purge) purge_pend <= 1'b0;
        end
    end

    // table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_v    <= '0;
            tbl_p    <= '0;
            tbl_a    <= '0;
            tbl_port <= '0;
            tbl_st   <= '0;
        end else if (learn_valid) begin
            if (l_hit) begin
                if (!tbl_p[l_idx]) begin
                    tbl_port[l_idx] <= learn_port;
                    tbl_st[l_idx]   <= cur_stamp;
                end
            end else if (l_free) begin
                tbl_v[l_fidx]    <= 1'b1;
                tbl_p[l_fidx]    <= 1'b0;
                tbl_a[l_fidx]    <= learn_addr;
                tbl_port[l_fidx] <= learn_port;
                tbl_st[l_fidx]   <= cur_stamp;
            end
        end else if (do_purge) begin
            tbl_v <= tbl_v & ~purge_hit;
        end else if (do_exec) begin
            if (op_q == OP_INS_PERM && (h_hit || h_free)) begin
                tbl_v[h_hit ? h_idx : h_fidx]    <= 1'b1;
                tbl_p[h_hit ? h_idx : h_fidx]    <= 1'b1;
                tbl_a[h_hit ? h_idx : h_fidx]    <= addr_q;
                tbl_port[h_hit ? h_idx : h_fidx] <= port_q;
                tbl_st[h_hit ? h_idx : h_fidx]   <= cur_stamp;
            end else if (op_q == OP_DELETE && h_hit) begin
                tbl_v[h_idx] <= 1'b0;
            end
        end
    end

    // full flag and read results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_full    <= 1'b0;
            host_hit      <= 1'b0;
            host_perm     <= 1'b0;
            host_rd_port  <= '0;
            host_rd_stamp <= '0;
        end else begin
            if ((learn_valid && !l_hit && !l_free) ||
                (do_exec && op_q == OP_INS_PERM && !h_hit && !h_free))
                table_full <= 1'b1;
            else if ((do_purge && |purge_hit) ||
                     (do_exec && op_q == OP_DELETE && h_hit))
                table_full <= 1'b0;
            if (do_exec && op_q == OP_READ) begin
                host_hit      <= h_hit;
                host_perm     <= h_hit && tbl_p[h_idx];
                host_rd_port  <= h_hit ? tbl_port[h_idx] : '0;
                host_rd_stamp <= h_hit ? tbl_st[h_idx] : '0;
            end
        end
    end
endmodule

// File: rtl/age_stamp_ctrl_chk.sv
module age_stamp_ctrl_chk #(
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          incr_in,
    input logic [1:0]    cfg_incr_en,
    input logic          learn_valid,
    input logic          host_ack,
    input logic          table_full,
    input logic [SW-1:0] cur_stamp,
    input logic [SW-1:0] purge_stamp,
    input logic          bump_cur,
    input logic          bump_pur
);
    p_purge_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(incr_in) && cfg_incr_en == 2'b11 && !bump_pur)
        |=> purge_stamp == SW'($past(purge_stamp) + 1'b1));

    p_cur_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_incr_en != 2'b11 && !bump_cur) |=> cur_stamp == $past(cur_stamp));

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_learn_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        learn_valid |=> !$rose(host_ack));

    p_full_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(table_full) |-> ($past(learn_valid) || host_ack));

    p_pur_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_cur && !(incr_in && cfg_incr_en == 2'b11))
        |=> purge_stamp == $past(purge_stamp));
endmodule

bind age_stamp_ctrl age_stamp_ctrl_chk #(.SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .incr_in(incr_in), .cfg_incr_en(cfg_incr_en),
    .learn_valid(learn_valid), .host_ack(host_ack), .table_full(table_full),
    .cur_stamp(cur_stamp), .purge_stamp(purge_stamp),
    .bump_cur(bump_cur), .bump_pur(bump_pur)
);

// File: tb/age_stamp_ctrl_tb_top.sv
module age_stamp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        learn_valid = 1'b0;
    logic [47:0] learn_addr = '0;
    logic [5:0]  learn_port = '0;
    logic        incr_in = 1'b0;
    logic [1:0]  cfg_incr_en = 2'b11;
    logic        host_req = 1'b0;
    logic [2:0]  host_op = '0;
    logic [47:0] host_addr = '0;
    logic [5:0]  host_port = '0;
    logic        host_ack, host_hit, host_perm, table_full;
    logic [5:0]  host_rd_port;
    logic [7:0]  host_rd_stamp, cur_stamp, purge_stamp;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    age_stamp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .learn_valid(learn_valid), .learn_addr(learn_addr),
        .learn_port(learn_port), .incr_in(incr_in), .cfg_incr_en(cfg_incr_en),
        .host_req(host_req), .host_op(host_op), .host_addr(host_addr), .host_port(host_port),
        .host_ack(host_ack), .host_hit(host_hit), .host_perm(host_perm),
        .host_rd_port(host_rd_port), .host_rd_stamp(host_rd_stamp),
        .cur_stamp(cur_stamp), .purge_stamp(purge_stamp), .table_full(table_full)
    );

    localparam logic [47:0] A_A = 48'h0011_2233_0001;
    localparam logic [47:0] A_B = 48'h0011_2233_0002;
    localparam logic [47:0] A_C = 48'h0011_2233_0003;
    localparam logic [47:0] A_D = 48'h0011_2233_0004;
    localparam logic [47:0] A_P = 48'h0011_2233_00F0;
    localparam logic [47:0] A_X = 48'h0011_2233_0077;

    typedef struct packed {
        logic [1:0]  kind;   // 0 learn, 1 read and check, 2 host step current
        logic [47:0] addr;
        logic [5:0]  port;
        logic        hit;
        logic [5:0]  eport;
        logic [7:0]  est;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'd0, A_A, 6'd1, 1'b0, 6'd0, 8'd0},
        '{2'd0, A_B, 6'd2, 1'b0, 6'd0, 8'd0},
        '{2'd1, A_A, 6'd0, 1'b1, 6'd1, 8'd0},
        '{2'd2, 48'd0, 6'd0, 1'b0, 6'd0, 8'd0},
        '{2'd0, A_A, 6'd5, 1'b0, 6'd0, 8'd0},
        '{2'd1, A_A, 6'd0, 1'b1, 6'd5, 8'd1},
        '{2'd1, A_B, 6'd0, 1'b1, 6'd2, 8'd0},
        '{2'd0, A_C, 6'd7, 1'b0, 6'd0, 8'd0},
        '{2'd1, A_C, 6'd0, 1'b1, 6'd7, 8'd1},
        '{2'd1, A_D, 6'd0, 1'b0, 6'd0, 8'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic learn(input logic [47:0] a, input logic [5:0] p);
        @(negedge clk);
        learn_valid = 1'b1;
        learn_addr  = a;
        learn_port  = p;
        @(negedge clk);
        learn_valid = 1'b0;
    endtask

    task automatic hop(input logic [2:0] op, input logic [47:0] a, input logic [5:0] p);
        @(negedge clk);
        host_req  = 1'b1;
        host_op   = op;
        host_addr = a;
        host_port = p;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
    endtask

    task automatic pulse_incr(input int width);
        @(negedge clk);
        incr_in = 1'b1;
        repeat (width) @(negedge clk);
        incr_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        do_reset();
        // R1 reset state
        chk(cur_stamp == 8'd0, "R1", "cur", cur_stamp, 0);
        chk(purge_stamp == 8'd0, "R1", "purge", purge_stamp, 0);
        chk(!table_full && !host_ack, "R1", "flags", {table_full, host_ack}, 0);
        hop(3'd3, A_A, 6'd0);
        chk(!host_hit, "R1", "empty read", host_hit, 0);

        // R5 R6 learning and refresh, table-driven
        for (int i = 0; i < 10; i++) begin
            unique case (VECS[i].kind)
                2'd0: learn(VECS[i].addr, VECS[i].port);
                2'd2: hop(3'd4, 48'd0, 6'd0);
                default: begin
                    hop(3'd3, VECS[i].addr, 6'd0);
                    chk(host_hit == VECS[i].hit, "R5_R6", "hit", host_hit, VECS[i].hit);
                    if (VECS[i].hit) begin
                        chk(host_rd_port == VECS[i].eport, "R5_R6", "port", host_rd_port, VECS[i].eport);
                        chk(host_rd_stamp == VECS[i].est, "R5_R6", "stamp", host_rd_stamp, VECS[i].est);
                    end
                end
            endcase
        end
        chk(cur_stamp == 8'd1 && purge_stamp == 8'd0, "R11", "step current",
            {cur_stamp, purge_stamp}, 16'h0100);

        // R7 permanent row resists learning (R10 insert)
        hop(3'd1, A_P, 6'd9);
        learn(A_P, 6'd3);
        hop(3'd3, A_P, 6'd0);
        chk(host_hit && host_perm && host_rd_port == 6'd9, "R7", "perm row",
            {host_hit, host_perm, host_rd_port}, {2'b11, 6'd9});

        // R2 R4 increment and purge: A,C stamp 1 go; B stamp 0 and P stay
        pulse_incr(1);
        chk(cur_stamp == 8'd2 && purge_stamp == 8'd1, "R2", "step both",
            {cur_stamp, purge_stamp}, 16'h0201);
        hop(3'd3, A_A, 6'd0);
        chk(!host_hit, "R4", "A purged", host_hit, 0);
        hop(3'd3, A_C, 6'd0);
        chk(!host_hit, "R4", "C purged", host_hit, 0);
        hop(3'd3, A_B, 6'd0);
        chk(host_hit, "R4", "B kept", host_hit, 1);
        hop(3'd3, A_P, 6'd0);
        chk(host_hit, "R4", "perm kept", host_hit, 1);

        // R11 step purge alone
        hop(3'd5, 48'd0, 6'd0);
        chk(cur_stamp == 8'd2 && purge_stamp == 8'd2, "R11", "step purge",
            {cur_stamp, purge_stamp}, 16'h0202);

        // R3 disabled increment
        cfg_incr_en = 2'b10;
        pulse_incr(1);
        chk(cur_stamp == 8'd2 && purge_stamp == 8'd2, "R3", "disabled",
            {cur_stamp, purge_stamp}, 16'h0202);
        hop(3'd3, A_B, 6'd0);
        chk(host_hit, "R3", "B untouched", host_hit, 1);

        // R2 held high counts once
        cfg_incr_en = 2'b11;
        pulse_incr(6);
        chk(cur_stamp == 8'd3 && purge_stamp == 8'd3, "R2", "held once",
            {cur_stamp, purge_stamp}, 16'h0303);

        // R10 delete
        hop(3'd2, A_B, 6'd0);
        hop(3'd3, A_B, 6'd0);
        chk(!host_hit, "R10", "deleted", host_hit, 0);

        // R9 learn priority over host work
        @(negedge clk);
        learn_valid = 1'b1; learn_addr = A_X; learn_port = 6'd4;
        host_req = 1'b1; host_op = 3'd3; host_addr = A_X; host_port = 6'd0;
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (host_ack) seen = 1'b1;
        end
        chk(!seen, "R9", "ack held off", seen, 0);
        learn_valid = 1'b0;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
        chk(host_hit && host_rd_port == 6'd4 && host_rd_stamp == 8'd3, "R9", "read after learn",
            {host_hit, host_rd_port, host_rd_stamp}, {1'b1, 6'd4, 8'd3});

        // R8 full behaviour
        do_reset();
        for (int i = 0; i < 16; i++) learn(48'h100 + 48'(i), 6'(i));
        chk(!table_full, "R8", "sixteen fit", table_full, 0);
        learn(48'h200, 6'd33);
        chk(table_full, "R8", "full set", table_full, 1);
        hop(3'd3, 48'h200, 6'd0);
        chk(!host_hit, "R8", "dropped", host_hit, 0);
        learn(48'h100, 6'd7);
        chk(table_full, "R8", "sticky", table_full, 1);
        hop(3'd2, 48'h105, 6'd0);
        chk(!table_full, "R8", "cleared by delete", table_full, 0);
        learn(48'h200, 6'd33);
        hop(3'd3, 48'h200, 6'd0);
        chk(host_hit && host_rd_port == 6'd33, "R8", "learned after free",
            {host_hit, host_rd_port}, {1'b1, 6'd33});
        chk(!table_full, "R8", "no new full", table_full, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule